// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter. It repeats a fixed conversion cycle made of three phases. First it closes the zeroing switch so the analog loop can null its own offset. Then it connects the unknown input to the integrator for a constant number of clocks. Finally it connects a reference of opposite sign and counts clocks until the comparator reports that the integrator has returned through zero. The integrator, the switches and the reference voltage stay outside the block. The block drives one select line for each switch and reads a single comparator bit.

Each phase has its own length parameter, so the full cycle length never varies. The defaults give a high-resolution mode with 10,000 zeroing clocks, 10,000 signal clocks and a 20,000-clock reference slot, for 40,000 clocks in all. A lower-resolution mode, with a 1,000-clock signal window, is obtained by overriding the same parameters.

At the end of every cycle the block publishes three values: the clock count, the sign of the input and an overrange flag. A one-clock done strobe marks the update. Because the sign is taken from the conversion in progress, a multiplexer ahead of the converter can switch channels freely between cycles.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset the phases repeat in a fixed order: the zeroing phase for ZERO_CLKS clocks, the signal phase for SIG_CLKS clocks, then the reference slot for REF_CLKS clocks. The cycle then starts again with the zeroing phase.
- R2: In any clock at most one of sw_zero, sw_signal, sw_ref_pos and sw_ref_neg is high. sw_zero is high for the whole zeroing phase and sw_signal for the whole signal phase.
- R3: The input sign comes from the value of cmp_high in the last clock of the signal phase of the same conversion.
  - If cmp_high is 1, the next result has pol_neg = 0 and sw_ref_neg drives the reference slot.
  - If cmp_high is 0, the next result has pol_neg = 1 and sw_ref_pos drives the slot.
  - The sign of an earlier conversion has no effect.
- R4: The result is the zero-based index, within the reference slot, of the first clock in which cmp_high differs from the latched sign. The first clock of the slot has index 0.
- R5: From the clock after the crossing until the end of the slot, both reference selects are low. Later changes of cmp_high in that slot do not change the result.
- R6: If cmp_high never differs from the latched sign during the slot, overrange is 1 and the result saturates at REF_CLKS. Otherwise overrange is 0.
- R7: done is high for exactly one clock, the first clock of the next zeroing phase. result, pol_neg and overrange change only together with done and hold their values at all other times.
- R8: During reset and in the first clock after it, sw_zero is 1, the other selects are 0, and done, result, pol_neg and overrange are 0.
- R9: cmp_high has no effect during the zeroing phase or in any signal-phase clock except the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_high | input | 1 | Comparator bit: 1 when the integrator output is above zero |
| sw_zero | output | 1 | Select for the offset-nulling switch |
| sw_signal | output | 1 | Select for the input switch |
| sw_ref_pos | output | 1 | Select for the positive reference (used when the input is negative) |
| sw_ref_neg | output | 1 | Select for the negative reference (used when the input is positive) |
| result | output | $clog2(REF_CLKS+1) | Clock count of the last finished conversion |
| pol_neg | output | 1 | 1 when the last finished conversion had a negative input |
| overrange | output | 1 | 1 when the last reference slot ended without a crossing |
| done | output | 1 | One-clock strobe marking a new result |

## Verification
Successive conversions alternate the comparator level at the end of the signal window. This separates a sign taken from the current conversion from one carried over from the previous conversion. Crossing indices at 0, in the middle of the slot and in the last slot clock test the count against the slot edges, and slots with no crossing at all test saturation. Other runs let the comparator toggle during zeroing, during the early signal clocks and after a crossing. These show that only the final signal-phase sample and the first reference-slot change ever count.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_ZERO   = 2'd0,
    PH_SIGNAL = 2'd1,
    PH_DEINT  = 2'd2
  } phase_t;

  // bits needed to hold the value n
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // the integrator has passed zero once the comparator disagrees with the held sign
  function automatic logic zero_crossed(input logic cmp_now, input logic held_sign);
    return cmp_now ^ held_sign;
  endfunction

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_ZERO:   return PH_SIGNAL;
      PH_SIGNAL: return PH_DEINT;
      default:   return PH_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/dsc_phase_timer.sv
module dsc_phase_timer
  import dsc_pkg::*;
#(
  parameter int ZERO_CLKS = 10000,
  parameter int SIG_CLKS  = 10000,
  parameter int REF_CLKS  = 20000,
  parameter int CW        = width_for(max3(ZERO_CLKS, SIG_CLKS, REF_CLKS))
) (
  input  logic          clk,
  input  logic          rst_n,
  output phase_t        phase,
  output logic [CW-1:0] tick,
  output logic          phase_last
);

  logic [CW-1:0] len_m1;

  always_comb begin
    case (phase)
      PH_ZERO:   len_m1 = CW'(ZERO_CLKS - 1);
      PH_SIGNAL: len_m1 = CW'(SIG_CLKS - 1);
      default:   len_m1 = CW'(REF_CLKS - 1);
    endcase
  end

  assign phase_last = (tick == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_ZERO;
      tick  <= '0;
    end else if (phase_last) begin
      phase <= next_phase(phase);
      tick  <= '0;
    end else begin
      tick  <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/dsc_slope_tracker.sv
module dsc_slope_tracker
  import dsc_pkg::*;
#(
  parameter int REF_CLKS = 20000,
  parameter int CW       = 15,
  parameter int RW       = width_for(REF_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic [CW-1:0] tick,
  input  logic          phase_last,
  input  logic          cmp_high,
  output logic          sign_hold,
  output logic          crossed,
  output logic          crossing_evt,
  output logic          slot_end,
  output logic [RW-1:0] result,
  output logic          pol_neg,
  output logic          overrange,
  output logic          done
);

  logic [RW-1:0] cap_cnt;
  logic          sig_end;

  assign sig_end      = (phase == PH_SIGNAL) && phase_last;
  assign slot_end     = (phase == PH_DEINT) && phase_last;
  assign crossing_evt = (phase == PH_DEINT) && !crossed && zero_crossed(cmp_high, sign_hold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_hold <= 1'b0;
      crossed   <= 1'b0;
      cap_cnt   <= '0;
      result    <= '0;
      pol_neg   <= 1'b0;
      overrange <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sig_end) begin
        sign_hold <= cmp_high;
        crossed   <= 1'b0;
      end
      if (crossing_evt) begin
        crossed <= 1'b1;
        cap_cnt <= RW'(tick);
      end
      if (slot_end) begin
        done    <= 1'b1;
        pol_neg <= !sign_hold;
        if (crossed) begin
          result    <= cap_cnt;
          overrange <= 1'b0;
        end else if (crossing_evt) begin
          result    <= RW'(tick);
          overrange <= 1'b0;
        end else begin
          result    <= RW'(REF_CLKS);
          overrange <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dsc_switch_drive.sv
module dsc_switch_drive
  import dsc_pkg::*;
(
  input  phase_t phase,
  input  logic   crossed,
  input  logic   sign_hold,
  output logic   sw_zero,
  output logic   sw_signal,
  output logic   sw_ref_pos,
  output logic   sw_ref_neg
);

  logic ref_on;

  assign ref_on     = (phase == PH_DEINT) && !crossed;
  assign sw_zero    = (phase == PH_ZERO);
  assign sw_signal  = (phase == PH_SIGNAL);
  assign sw_ref_pos = ref_on && !sign_hold;
  assign sw_ref_neg = ref_on && sign_hold;

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int ZERO_CLKS = 10000,
  parameter int SIG_CLKS  = 10000,
  parameter int REF_CLKS  = 20000,
  localparam int CW       = width_for(max3(ZERO_CLKS, SIG_CLKS, REF_CLKS)),
  localparam int RW       = width_for(REF_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_high,
  output logic          sw_zero,
  output logic          sw_signal,
  output logic          sw_ref_pos,
  output logic          sw_ref_neg,
  output logic [RW-1:0] result,
  output logic          pol_neg,
  output logic          overrange,
  output logic          done
);

  phase_t        phase;
  logic [CW-1:0] tick;
  logic          phase_last;
  logic          sign_hold;
  logic          crossed;
  logic          crossing_evt;
  logic          slot_end;

  dsc_phase_timer #(
    .ZERO_CLKS(ZERO_CLKS), .SIG_CLKS(SIG_CLKS), .REF_CLKS(REF_CLKS), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .tick(tick), .phase_last(phase_last)
  );

  dsc_slope_tracker #(.REF_CLKS(REF_CLKS), .CW(CW), .RW(RW)) u_track (
    .clk(clk), .rst_n(rst_n), .phase(phase), .tick(tick), .phase_last(phase_last),
    .cmp_high(cmp_high), .sign_hold(sign_hold), .crossed(crossed),
    .crossing_evt(crossing_evt), .slot_end(slot_end), .result(result),
    .pol_neg(pol_neg), .overrange(overrange), .done(done)
  );

  dsc_switch_drive u_sw (
    .phase(phase), .crossed(crossed), .sign_hold(sign_hold),
    .sw_zero(sw_zero), .sw_signal(sw_signal),
    .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg)
  );

endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int REF_CLKS = 20000,
  parameter int RW       = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_zero,
  input logic          sw_signal,
  input logic          sw_ref_pos,
  input logic          sw_ref_neg,
  input logic [RW-1:0] result,
  input logic          pol_neg,
  input logic          overrange,
  input logic          done,
  input logic          crossing_evt,
  input logic          slot_end
);

  logic ref_any;
  assign ref_any = sw_ref_pos || sw_ref_neg;

  p_one_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_zero, sw_signal, sw_ref_pos, sw_ref_neg}));

  p_ref_follows_signal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_any) |-> $past(sw_signal));

  p_neutral_after_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crossing_evt |=> !ref_any);

  p_done_after_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(pol_neg) && $stable(overrange)));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overrange) |-> (result == RW'(REF_CLKS)));

endmodule

bind dual_slope_seq dual_slope_seq_chk #(.REF_CLKS(REF_CLKS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_zero(sw_zero), .sw_signal(sw_signal),
  .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg), .result(result),
  .pol_neg(pol_neg), .overrange(overrange), .done(done),
  .crossing_evt(crossing_evt), .slot_end(slot_end)
);

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;

  localparam int ZC = 6;
  localparam int SC = 5;
  localparam int RC = 12;
  localparam int RW = $clog2(RC + 1);
  localparam int TOTAL = ZC + SC + RC;

  typedef struct {
    int cnt;
    int neg;
    int ovr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_high = 1'b0;
  logic          sw_zero, sw_signal, sw_ref_pos, sw_ref_neg;
  logic [RW-1:0] result;
  logic          pol_neg, overrange, done;

  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  dual_slope_seq #(.ZERO_CLKS(ZC), .SIG_CLKS(SC), .REF_CLKS(RC)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_high(cmp_high),
    .sw_zero(sw_zero), .sw_signal(sw_signal),
    .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg),
    .result(result), .pol_neg(pol_neg), .overrange(overrange), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sw_word();
    return {28'd0, sw_zero, sw_signal, sw_ref_pos, sw_ref_neg};
  endfunction

  // one conversion; p = comparator level at end of signal phase, k = crossing index (-1: none)
  task automatic run_conv(input bit p, input int k, input bit bounce, input bit noise);
    exp_t e;
    e.cnt = (k >= 0) ? k : RC;
    e.neg = p ? 0 : 1;
    e.ovr = (k >= 0) ? 0 : 1;
    sb_q.push_back(e);
    for (int t = 0; t < TOTAL; t++) begin
      int want;
      int j;
      j = t - ZC - SC;
      if (t < ZC)                  want = 8;
      else if (t < ZC + SC)        want = 4;
      else if (k >= 0 && j > k)    want = 0;
      else                         want = p ? 1 : 2;
      chk(sw_word() == want, "R1/R2/R5 switch select", sw_word(), want);
      if (t != 0) chk(done == 1'b0, "R7 done only at cycle start", int'(done), 0);
      if (t < ZC + SC - 1)         cmp_high = noise ? t[0] : !p;   // R9: ignored
      else if (t == ZC + SC - 1)   cmp_high = p;                    // R3: sign sample
      else if (k < 0 || j < k)     cmp_high = p;
      else if (bounce && j > k + 1) cmp_high = p;                   // R5: ignored bounce
      else                         cmp_high = !p;                   // R4: crossing
      @(negedge clk);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 done without pending conversion", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(int'(result) == e.cnt, "R4/R6 result count", int'(result), e.cnt);
          chk(int'(pol_neg) == e.neg, "R3 polarity", int'(pol_neg), e.neg);
          chk(int'(overrange) == e.ovr, "R6 overrange", int'(overrange), e.ovr);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(sw_word() == 8, "R8 reset switches", sw_word(), 8);
    chk(done == 1'b0, "R8 reset done", int'(done), 0);
    chk(int'(result) == 0, "R8 reset result", int'(result), 0);
    chk(pol_neg == 1'b0 && overrange == 1'b0, "R8 reset flags",
        int'({pol_neg, overrange}), 0);
    rst_n = 1'b1;
    run_conv(1'b1, 4, 1'b0, 1'b0);   // R4 mid-slot, positive input
    run_conv(1'b0, 7, 1'b0, 1'b0);   // R3 alternate sign
    run_conv(1'b1, 0, 1'b0, 1'b0);   // R4 crossing at index 0
    run_conv(1'b0, RC - 1, 1'b0, 1'b0); // R4 last slot clock
    run_conv(1'b1, -1, 1'b0, 1'b0);  // R6 overrange
    run_conv(1'b0, 2, 1'b1, 1'b0);   // R5 bounce after crossing
    run_conv(1'b0, -1, 1'b0, 1'b1);  // R6 overrange, negative input, R9 noise
    run_conv(1'b1, 5, 1'b1, 1'b1);   // R9 noise + R5 bounce
    @(negedge clk);
    chk(sb_q.size() == 0, "R7 every conversion reported", sb_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule